// File: doc/BRIEF.md
# Memory-Card Host Interrupt Status and Mask Unit

This block keeps the interrupt state of a memory-card host controller. Hardware event pulses latch into a raw status register. Software reads that register, or its masked view, through a 32-bit register port and clears bits by writing ones. A global control register holds the enable that gates the single level-sensitive interrupt line. The block also holds a card-status register whose present flag follows a card-detect level input, and a DMA status register with its own set pulses and a narrow clearable field.

Card detection is edge based. A rising edge on the detect level counts as an insert, and a falling edge counts as a removal. Each of these events sets one raw bit and clears the matching opposite bit in the same cycle. The card-status register reports presence, and software can also clear it by writing a one. The interrupt output is registered. Software sees it one cycle after the status, mask or enable change that caused it.

Top module: `hirq_unit`

## Requirements
- R1: After reset these registers read as follows: global control 0x00000300, mask 0, masked status 0, raw status 0, card status 0x00000100, DMA status 0. irq_o reads 0.
- R2: The register map uses word addresses. Global control is at 0x00, mask at 0x04, masked status at 0x08, raw status at 0x0C, card status at 0x10 and DMA status at 0x14. Any other address reads 0. A read of the masked status returns raw status AND mask.
- R3: irq_o is 1 exactly one cycle after a cycle in which global-control bit 4 is 1 and (raw AND mask) is nonzero. Otherwise it is 0.
- R4: A write to the masked-status address or to the raw-status address clears each raw bit that is 1 in the written data. All other raw bits are left unchanged.
- R5: Each evt_i bit 29..0 that is 1 for a cycle sets the same raw bit. When that set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R6: A rising edge on card_det_i sets raw bit 30, clears raw bit 31 and sets card-status bit 8. A falling edge sets raw bit 31, clears raw bit 30 and clears card-status bit 8. evt_i bits 31 and 30 have no effect.
- R7: A write to card status with data bit 8 equal to 1 clears the present bit. A card-insert edge in the same cycle wins.
- R8: Each dma_evt_i bit that is 1 sets the same DMA status bit. A DMA status write clears only bits 9..0 that are 1 in the data. Bits 31..10 are never changed by a write.
- R9: A global control write stores the data with bits 2..0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Byte address of the register access |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| evt_i | input | 32 | Raw status set pulses (bits 31..30 ignored) |
| dma_evt_i | input | 32 | DMA status set pulses |
| card_det_i | input | 1 | Card-detect level, 1 means a card is present |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The hardest case to reach is a hardware set and a software clear landing on the same raw bit in the same clock cycle. The bench reaches it with one task that drives the event pulse and the clearing write on the same falling edge, so both are sampled by one rising edge. The card-detect edges are produced by toggling the level between register accesses, and the raw and card-status registers are read back after each edge. The one-cycle lag of irq_o is checked by sampling the line twice after a mask or enable write: on the falling edge right after the write it must still hold the old value, and on the next falling edge it must show the new one.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int DW = 32;

  // word indices of the register map
  localparam int IDX_GCTL  = 0;
  localparam int IDX_MASK  = 1;
  localparam int IDX_MSTAT = 2;
  localparam int IDX_RAW   = 3;
  localparam int IDX_CARD  = 4;
  localparam int IDX_DMA   = 5;

  localparam logic [DW-1:0] GCTL_RST     = 32'h0000_0300;
  localparam logic [DW-1:0] GCTL_SELFCLR = 32'h0000_0007;
  localparam int            GIE_BIT      = 4;

  localparam int CARD_INS_BIT = 30;
  localparam int CARD_REM_BIT = 31;
  localparam int PRESENT_BIT  = 8;

  localparam logic [DW-1:0] CARD_EVT_MASK = (32'h1 << CARD_INS_BIT) | (32'h1 << CARD_REM_BIT);
  localparam logic [DW-1:0] DMA_WR_MASK   = 32'h0000_03FF;

  typedef struct packed {
    logic gctl;
    logic mask;
    logic stat_clr;
    logic card;
    logic dma;
  } hirq_wsel_t;
endpackage

// File: rtl/hirq_decode.sv
module hirq_decode
  import hirq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  output hirq_wsel_t    wsel_o
);
  localparam int IW = AW - 2;

  logic [IW-1:0] idx;
  assign idx = addr_i[AW-1:2];

  always_comb begin
    wsel_o          = '0;
    wsel_o.gctl     = we_i && (idx == IW'(IDX_GCTL));
    wsel_o.mask     = we_i && (idx == IW'(IDX_MASK));
    // both status views clear the same raw bits
    wsel_o.stat_clr = we_i && ((idx == IW'(IDX_MSTAT)) || (idx == IW'(IDX_RAW)));
    wsel_o.card     = we_i && (idx == IW'(IDX_CARD));
    wsel_o.dma      = we_i && (idx == IW'(IDX_DMA));
  end
endmodule

// File: rtl/hirq_card.sv
module hirq_card
  import hirq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          card_det_i,
  input  logic          clr_en_i,
  input  logic [DW-1:0] clr_data_i,
  output logic          present_o,
  output logic          ins_o,
  output logic          rem_o
);
  logic det_q;

  // previous level resets to present, matching the status reset value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) det_q <= 1'b1;
    else         det_q <= card_det_i;
  end

  assign ins_o = card_det_i & ~det_q;
  assign rem_o = ~card_det_i & det_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              present_o <= 1'b1;
    else if (ins_o)                           present_o <= 1'b1;
    else if (rem_o)                           present_o <= 1'b0;
    else if (clr_en_i && clr_data_i[PRESENT_BIT]) present_o <= 1'b0;
  end
endmodule

// File: rtl/hirq_raw_stat.sv
module hirq_raw_stat
  import hirq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic          clr_en_i,
  input  logic [DW-1:0] clr_data_i,
  input  logic          ins_i,
  input  logic          rem_i,
  output logic [DW-1:0] raw_o
);
  logic [DW-1:0] set_v, clr_v, raw_d;

  assign set_v = evt_i & ~CARD_EVT_MASK;
  assign clr_v = clr_en_i ? clr_data_i : '0;

  always_comb begin
    raw_d = (raw_o & ~clr_v) | set_v;  // set wins over clear
    if (ins_i) begin
      raw_d[CARD_INS_BIT] = 1'b1;
      raw_d[CARD_REM_BIT] = 1'b0;
    end else if (rem_i) begin
      raw_d[CARD_INS_BIT] = 1'b0;
      raw_d[CARD_REM_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_o <= '0;
    else         raw_o <= raw_d;
  end
endmodule

// File: rtl/hirq_dma_stat.sv
module hirq_dma_stat
  import hirq_pkg::*;
#(
  parameter logic [DW-1:0] WMASK = DMA_WR_MASK
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          clr_en_i,
  input  logic [DW-1:0] clr_data_i,
  output logic [DW-1:0] stat_o
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic clr_b;
    if (WMASK[b]) begin : g_wr
      assign clr_b = clr_en_i & clr_data_i[b];
    end else begin : g_ro
      assign clr_b = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_o[b] <= 1'b0;
      else if (set_i[b]) stat_o[b] <= 1'b1;
      else if (clr_b)    stat_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/hirq_unit.sv
module hirq_unit
  import hirq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic [31:0]   evt_i,
  input  logic [31:0]   dma_evt_i,
  input  logic          card_det_i,
  output logic          irq_o
);
  localparam int IW = AW - 2;

  hirq_wsel_t    wsel;
  logic [DW-1:0] gctl_q, mask_q, raw, dma_stat;
  logic          present, ins, rem;

  hirq_decode #(.AW(AW)) u_dec (
    .addr_i (addr_i),
    .we_i   (we_i),
    .wsel_o (wsel)
  );

  hirq_card u_card (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .card_det_i (card_det_i),
    .clr_en_i   (wsel.card),
    .clr_data_i (wdata_i),
    .present_o  (present),
    .ins_o      (ins),
    .rem_o      (rem)
  );

  hirq_raw_stat u_raw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .clr_en_i   (wsel.stat_clr),
    .clr_data_i (wdata_i),
    .ins_i      (ins),
    .rem_i      (rem),
    .raw_o      (raw)
  );

  hirq_dma_stat #(.WMASK(DMA_WR_MASK)) u_dma (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (dma_evt_i),
    .clr_en_i   (wsel.dma),
    .clr_data_i (wdata_i),
    .stat_o     (dma_stat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gctl_q <= GCTL_RST;
      mask_q <= '0;
    end else begin
      if (wsel.gctl) gctl_q <= wdata_i & ~GCTL_SELFCLR;
      if (wsel.mask) mask_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= gctl_q[GIE_BIT] & (|(raw & mask_q));
  end

  logic [IW-1:0] ridx;
  assign ridx = addr_i[AW-1:2];

  always_comb begin
    rdata_o = '0;
    case (ridx)
      IW'(IDX_GCTL):  rdata_o = gctl_q;
      IW'(IDX_MASK):  rdata_o = mask_q;
      IW'(IDX_MSTAT): rdata_o = raw & mask_q;
      IW'(IDX_RAW):   rdata_o = raw;
      IW'(IDX_CARD):  rdata_o = DW'(present) << PRESENT_BIT;
      IW'(IDX_DMA):   rdata_o = dma_stat;
      default:        rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/hirq_unit_chk.sv
module hirq_unit_chk
  import hirq_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic [DW-1:0] gctl_q,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] raw,
  input logic [DW-1:0] dma_stat,
  input logic [DW-1:0] evt_i,
  input logic [DW-1:0] dma_evt_i,
  input logic          present,
  input logic          ins
);
  // R3: registered output lags its cause by one cycle
  a_r3_irq_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(gctl_q[GIE_BIT] && (|(raw & mask_q))));

  // R5: a pulsed event bit is set on the next cycle whatever the clear
  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(evt_i & ~CARD_EVT_MASK) |=>
      (raw & $past(evt_i & ~CARD_EVT_MASK)) == $past(evt_i & ~CARD_EVT_MASK));

  // R6: insert and remove bits are never set together
  a_r6_card_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(raw[CARD_INS_BIT] && raw[CARD_REM_BIT]));

  // R6: insert edge yields insert bit and present flag
  a_r6_insert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins |=> raw[CARD_INS_BIT] && !raw[CARD_REM_BIT] && present);

  // R8: upper DMA bits are never lowered
  a_r8_dma_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (dma_stat[31:10] & $past(dma_stat[31:10])) == $past(dma_stat[31:10]));

  // R8: DMA set pulse lands
  a_r8_dma_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |dma_evt_i |=> (dma_stat & $past(dma_evt_i)) == $past(dma_evt_i));

  // R9: self-clearing control bits never held
  a_r9_gctl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gctl_q[2:0] == 3'b000);
endmodule

bind hirq_unit hirq_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .gctl_q    (gctl_q),
  .mask_q    (mask_q),
  .raw       (raw),
  .dma_stat  (dma_stat),
  .evt_i     (evt_i),
  .dma_evt_i (dma_evt_i),
  .present   (present),
  .ins       (ins)
);

// File: tb/sim_hirq_unit.sv
`timescale 1ns/1ps
module sim_hirq_unit;
  localparam int AW = 8;
  localparam logic [7:0] A_GCTL = 8'h00, A_MASK = 8'h04, A_MSTAT = 8'h08,
                         A_RAW = 8'h0C, A_CARD = 8'h10, A_DMA = 8'h14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          we_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [31:0]   evt_i = '0;
  logic [31:0]   dma_evt_i = '0;
  logic          card_det_i = 1'b1;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  hirq_unit #(.AW(AW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i),
    .dma_evt_i(dma_evt_i), .card_det_i(card_det_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse_evt(input logic [31:0] e);
    @(negedge clk_i);
    evt_i = e;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_GCTL, d);  check("R1 gctl", d, 32'h300);
    rd(A_MASK, d);  check("R1 mask", d, 0);
    rd(A_MSTAT, d); check("R1 mstat", d, 0);
    rd(A_RAW, d);   check("R1 raw", d, 0);
    rd(A_CARD, d);  check("R1 card", d, 32'h100);
    rd(A_DMA, d);   check("R1 dma", d, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
    rd(8'h18, d);   check("R2 unmapped", d, 0);
  endtask

  task automatic t_gctl;
    logic [31:0] d;
    wr(A_GCTL, 32'hFFFF_FFFF);
    rd(A_GCTL, d); check("R9 gctl all ones", d, 32'hFFFF_FFF8);
    wr(A_GCTL, 32'h0000_0017);
    rd(A_GCTL, d); check("R9 gctl enable", d, 32'h0000_0010);
  endtask

  task automatic t_mask_irq;
    logic [31:0] d;
    pulse_evt(32'h0000_0005);
    rd(A_RAW, d); check("R5 event set", d, 32'h5);
    wr(A_MASK, 32'h0000_0004);
    // at this negedge mask is updated but irq_o is not yet
    check("R3 irq lag", {31'b0, irq_o}, 0);
    @(negedge clk_i);
    check("R3 irq asserted", {31'b0, irq_o}, 1);
    rd(A_MSTAT, d); check("R2 masked view", d, 32'h4);
    wr(A_GCTL, 32'h0);
    check("R3 irq holds one cycle", {31'b0, irq_o}, 1);
    @(negedge clk_i);
    check("R3 irq gated by enable", {31'b0, irq_o}, 0);
    wr(A_GCTL, 32'h10);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(A_RAW, 32'h0000_0001);
    rd(A_RAW, d); check("R4 raw addr clear", d, 32'h4);
    wr(A_MSTAT, 32'h0000_0004);
    rd(A_RAW, d); check("R4 mstat addr clear", d, 32'h0);
    @(negedge clk_i);
    check("R4 irq drops", {31'b0, irq_o}, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk_i);
    addr_i = A_RAW; wdata_i = 32'h0000_0018; we_i = 1'b1; evt_i = 32'h0000_0008;
    @(negedge clk_i);
    we_i = 1'b0; evt_i = '0;
    rd(A_RAW, d); check("R5 set beats clear", d, 32'h8);
    wr(A_RAW, 32'hFFFF_FFFF);
  endtask

  task automatic t_card;
    logic [31:0] d;
    @(negedge clk_i); card_det_i = 1'b0;
    @(negedge clk_i);
    rd(A_RAW, d);  check("R6 remove raw", d, 32'h8000_0000);
    rd(A_CARD, d); check("R6 remove present", d, 32'h0);
    @(negedge clk_i); card_det_i = 1'b1;
    @(negedge clk_i);
    rd(A_RAW, d);  check("R6 insert raw", d, 32'h4000_0000);
    rd(A_CARD, d); check("R6 insert present", d, 32'h100);
    wr(A_RAW, 32'hFFFF_FFFF);
    pulse_evt(32'hC000_0000);
    rd(A_RAW, d);  check("R6 evt 31:30 ignored", d, 32'h0);
    wr(A_CARD, 32'hFFFF_FEFF);
    rd(A_CARD, d); check("R7 clear needs bit 8", d, 32'h100);
    wr(A_CARD, 32'h0000_0100);
    rd(A_CARD, d); check("R7 present cleared", d, 32'h0);
  endtask

  task automatic t_dma;
    logic [31:0] d;
    @(negedge clk_i); dma_evt_i = 32'hFFFF_FFFF;
    @(negedge clk_i); dma_evt_i = '0;
    rd(A_DMA, d); check("R8 dma set", d, 32'hFFFF_FFFF);
    wr(A_DMA, 32'h0000_0000);
    rd(A_DMA, d); check("R8 dma zero write", d, 32'hFFFF_FFFF);
    wr(A_DMA, 32'hFFFF_FFFF);
    rd(A_DMA, d); check("R8 dma field clear", d, 32'hFFFF_FC00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_gctl();
    t_mask_irq();
    t_w1c();
    t_set_wins();
    t_card();
    t_dma();
    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule